// File: doc/BRIEF.md
# Four-Channel Ring Buffer Address Manager

This block keeps four circular byte buffers inside one shared external memory: video elementary data, audio elementary data, video packet-header data and audio packet-header data. Each buffer's region is set by a start page and an end page. A page is 256 bytes, so a region always begins on a 256-byte boundary and ends on the last byte of a page. A video source and an audio source each offer one byte per cycle, tagged as elementary or header data. The block picks the target buffer, issues a memory write at that buffer's write pointer and advances the pointer. Downstream consumers ask for bytes per buffer, and the block answers each granted read with a memory read at that buffer's read pointer.

Each source sees a request line. The line drops when free space in one of its target buffers falls below a programmable threshold, so the upstream side can hold the excess in its own storage. A beat is taken only when the source's request line is high, the target buffer has room, no configuration write is under way and the single memory port is free. The block issues at most one memory operation per cycle.

Top module: `chbuf_mgr`

## Requirements
- R1: After reset, both request lines are high, and there is no memory write, no memory read and no read grant.
- R2: With system mode off, buffers are selected as follows. Video elementary goes to buffer 0 and audio elementary to buffer 1. Video header goes to buffer 2 and audio header to buffer 3. Each accepted beat drives mem_we_o with the target's write pointer on mem_addr_o and the beat's byte on mem_wdata_o.
- R3: With system mode on, video header beats are written to buffer 3 and buffer 2 receives nothing.
- R4: A start or end value is a page number. A region spans byte {start,8'h00} through byte {end,8'hFF}. The first write after programming lands on the start byte, and each later write lands one byte higher.
- R5: A write or read pointer at the end byte of its region moves to the start byte next.
- R6: A buffer holds at most its region size minus one byte. A beat aimed at a full buffer is refused: the accept output is low, there is no memory write and no stored byte is overwritten.
- R7: A read request to an empty buffer gets no grant and no memory read.
- R8: A granted read drives mem_re_o with the buffer's read pointer on mem_addr_o. Reads return bytes in write order.
- R9: Writing a buffer's start or end value resets that buffer's pointers to its start byte and empties it. Other buffers are left alone. No beat is accepted in the cycle of a configuration write.
- R10: A buffer's room flag clears one cycle after its free space falls below its threshold, and sets one cycle after free space rises above it. When the two are equal, the flag keeps its value. The video request line is the AND of the room flags of buffer 0 and the current video-header target. The audio request line is the AND of the room flags of buffers 1 and 3. No beat is accepted while its request line is low.
- R11: A video beat wins the memory port over an audio beat. Any write wins over reads. Reads are granted round-robin, starting from the buffer after the last one granted, and buffer 0 comes first after reset.
- R12: A memory write and a memory read never occur in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| sys_mode_i | input | 1 | 1: system/program stream, all header data to buffer 3 |
| cfg_we_i | input | 1 | Configuration write strobe |
| cfg_buf_i | input | 2 | Buffer addressed by configuration write |
| cfg_field_i | input | 2 | 0 start page, 1 end page, 2 free-space threshold |
| cfg_data_i | input | 16 | Page number (low 8 bits) or threshold in bytes |
| vid_valid_i | input | 1 | Video beat present |
| vid_hdr_i | input | 1 | Video beat is header data |
| vid_data_i | input | 8 | Video byte |
| vid_req_o | output | 1 | Video request line |
| vid_acc_o | output | 1 | Video beat accepted this cycle |
| aud_valid_i | input | 1 | Audio beat present |
| aud_hdr_i | input | 1 | Audio beat is header data |
| aud_data_i | input | 8 | Audio byte |
| aud_req_o | output | 1 | Audio request line |
| aud_acc_o | output | 1 | Audio beat accepted this cycle |
| rd_req_i | input | 4 | Per-buffer read request |
| rd_gnt_o | output | 4 | One-hot read grant |
| mem_we_o | output | 1 | Memory write |
| mem_re_o | output | 1 | Memory read |
| mem_addr_o | output | 16 | Memory byte address |
| mem_wdata_o | output | 8 | Memory write data |

## Verification
The hardest states to reach are a buffer that is exactly full and a pointer that sits on the last byte of its region, since a buffer of the default size would take thousands of beats to get there. The stimulus first shrinks a buffer to a single 256-byte page. It then writes 255 beats and trades one read for one write until the write pointer crosses the page end, checking that no stored byte is lost on the way. The threshold hysteresis is driven to both edges by writing and reading one byte at a time around a threshold of 250.

// File: rtl/chbuf_pkg.sv
package chbuf_pkg;
  localparam int unsigned NBUF  = 4;
  localparam int unsigned BID_W = 2;
  localparam int unsigned PG_SH = 8;  // 256-byte pages

  typedef enum logic [BID_W-1:0] {
    BUF_VES  = 2'd0,
    BUF_AES  = 2'd1,
    BUF_VHDR = 2'd2,
    BUF_AHDR = 2'd3
  } buf_id_e;

  typedef enum logic [1:0] {
    CF_START = 2'd0,
    CF_END   = 2'd1,
    CF_THR   = 2'd2
  } cfg_field_e;
endpackage

// File: rtl/chbuf_ring.sv
module chbuf_ring
  import chbuf_pkg::*;
#(
  parameter int unsigned ADDR_W = 16,
  parameter int unsigned IDX    = 0
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cfg_we_i,
  input  cfg_field_e        cfg_field_i,
  input  logic [ADDR_W-1:0] cfg_data_i,
  input  logic              wr_en_i,
  input  logic              rd_en_i,
  output logic [ADDR_W-1:0] wr_addr_o,
  output logic [ADDR_W-1:0] rd_addr_o,
  output logic              full_o,
  output logic              empty_o,
  output logic              room_o
);
  localparam int unsigned PAGE_W = ADDR_W - PG_SH;
  localparam int unsigned QUART  = (2 ** PAGE_W) / NBUF;
  localparam logic [PAGE_W-1:0] DEF_START = PAGE_W'(IDX * QUART);
  localparam logic [PAGE_W-1:0] DEF_END   = PAGE_W'(IDX * QUART + QUART - 1);

  logic [PAGE_W-1:0] start_pg_q, end_pg_q;
  logic [ADDR_W-1:0] thr_q, wp_q, rp_q, fill_q;
  logic [ADDR_W-1:0] start_a, end_a, wp_nx, rp_nx;
  logic [ADDR_W:0]   size_w, free_w;
  logic              room_q;

  assign start_a = {start_pg_q, {PG_SH{1'b0}}};
  assign end_a   = {end_pg_q, {PG_SH{1'b1}}};
  assign size_w  = {1'b0, end_a} - {1'b0, start_a} + (ADDR_W+1)'(1);
  assign free_w  = size_w - (ADDR_W+1)'(1) - {1'b0, fill_q};
  assign wp_nx   = (wp_q == end_a) ? start_a : wp_q + ADDR_W'(1);
  assign rp_nx   = (rp_q == end_a) ? start_a : rp_q + ADDR_W'(1);

  assign full_o    = (wp_nx == rp_q);
  assign empty_o   = (wp_q == rp_q);
  assign wr_addr_o = wp_q;
  assign rd_addr_o = rp_q;
  assign room_o    = room_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      start_pg_q <= DEF_START;
      end_pg_q   <= DEF_END;
      thr_q      <= '0;
      wp_q       <= {DEF_START, {PG_SH{1'b0}}};
      rp_q       <= {DEF_START, {PG_SH{1'b0}}};
      fill_q     <= '0;
    end else if (cfg_we_i) begin
      unique case (cfg_field_i)
        CF_START: begin
          start_pg_q <= cfg_data_i[PAGE_W-1:0];
          wp_q       <= {cfg_data_i[PAGE_W-1:0], {PG_SH{1'b0}}};
          rp_q       <= {cfg_data_i[PAGE_W-1:0], {PG_SH{1'b0}}};
          fill_q     <= '0;
        end
        CF_END: begin
          end_pg_q <= cfg_data_i[PAGE_W-1:0];
          wp_q     <= start_a;
          rp_q     <= start_a;
          fill_q   <= '0;
        end
        CF_THR:  thr_q <= cfg_data_i;
        default: ;
      endcase
    end else begin
      if (wr_en_i) wp_q <= wp_nx;
      if (rd_en_i) rp_q <= rp_nx;
      if (wr_en_i && !rd_en_i) fill_q <= fill_q + ADDR_W'(1);
      else if (!wr_en_i && rd_en_i) fill_q <= fill_q - ADDR_W'(1);
    end
  end

  // hysteresis: equal keeps state
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) room_q <= 1'b1;
    else if (free_w < {1'b0, thr_q}) room_q <= 1'b0;
    else if (free_w > {1'b0, thr_q}) room_q <= 1'b1;
  end

  assert_no_write_full_R6 : assert property (@(posedge clk_i) disable iff (!rst_ni)
    full_o |-> !wr_en_i);
  assert_no_read_empty_R7 : assert property (@(posedge clk_i) disable iff (!rst_ni)
    empty_o |-> !rd_en_i);
  assert_wr_wrap_R5 : assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && !cfg_we_i && wp_q == end_a) |=> (wp_q == start_a));
  assert_rd_wrap_R5 : assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_en_i && !cfg_we_i && rp_q == end_a) |=> (rp_q == start_a));
  assert_fill_bound_R6 : assert property (@(posedge clk_i) disable iff (!rst_ni)
    ({1'b0, fill_q} < size_w));
endmodule

// File: rtl/chbuf_wr_route.sv
module chbuf_wr_route
  import chbuf_pkg::*;
#(
  parameter int unsigned DATA_W = 8
) (
  input  logic              sys_mode_i,
  input  logic              hold_i,
  input  logic              vid_valid_i,
  input  logic              vid_hdr_i,
  input  logic [DATA_W-1:0] vid_data_i,
  input  logic              vid_req_i,
  input  logic              aud_valid_i,
  input  logic              aud_hdr_i,
  input  logic [DATA_W-1:0] aud_data_i,
  input  logic              aud_req_i,
  input  logic [NBUF-1:0]   full_i,
  output logic              vid_acc_o,
  output logic              aud_acc_o,
  output logic [NBUF-1:0]   wr_en_o,
  output buf_id_e           sel_o,
  output logic [DATA_W-1:0] data_o
);
  buf_id_e vid_tgt, aud_tgt;

  always_comb begin
    if (!vid_hdr_i)      vid_tgt = BUF_VES;
    else if (sys_mode_i) vid_tgt = BUF_AHDR;
    else                 vid_tgt = BUF_VHDR;
    aud_tgt = aud_hdr_i ? BUF_AHDR : BUF_AES;
  end

  assign vid_acc_o = vid_valid_i && vid_req_i && !hold_i && !full_i[vid_tgt];
  assign aud_acc_o = aud_valid_i && aud_req_i && !hold_i && !full_i[aud_tgt] && !vid_acc_o;

  always_comb begin
    wr_en_o = '0;
    if (vid_acc_o)      wr_en_o[vid_tgt] = 1'b1;
    else if (aud_acc_o) wr_en_o[aud_tgt] = 1'b1;
    sel_o  = vid_acc_o ? vid_tgt : aud_tgt;
    data_o = vid_acc_o ? vid_data_i : aud_data_i;
  end
endmodule

// File: rtl/chbuf_rd_arb.sv
module chbuf_rd_arb
  import chbuf_pkg::*;
(
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            block_i,
  input  logic [NBUF-1:0] req_i,
  input  logic [NBUF-1:0] empty_i,
  output logic [NBUF-1:0] gnt_o,
  output buf_id_e         sel_o
);
  buf_id_e last_q;

  always_comb begin
    logic found;
    logic [BID_W-1:0] cand;
    found = 1'b0;
    gnt_o = '0;
    sel_o = last_q;
    for (int off = 1; off <= NBUF; off++) begin
      cand = BID_W'(int'(last_q) + off);
      if (!found && !block_i && req_i[cand] && !empty_i[cand]) begin
        found       = 1'b1;
        gnt_o[cand] = 1'b1;
        sel_o       = buf_id_e'(cand);
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     last_q <= buf_id_e'(NBUF - 1);
    else if (|gnt_o) last_q <= sel_o;
  end

  assert_gnt_onehot_R11 : assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(gnt_o));
  assert_gnt_requested_R8 : assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((gnt_o & ~req_i) == '0));
endmodule

// File: rtl/chbuf_mgr.sv
module chbuf_mgr
  import chbuf_pkg::*;
#(
  parameter int unsigned ADDR_W = 16,
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              sys_mode_i,
  input  logic              cfg_we_i,
  input  logic [BID_W-1:0]  cfg_buf_i,
  input  logic [1:0]        cfg_field_i,
  input  logic [ADDR_W-1:0] cfg_data_i,
  input  logic              vid_valid_i,
  input  logic              vid_hdr_i,
  input  logic [DATA_W-1:0] vid_data_i,
  output logic              vid_req_o,
  output logic              vid_acc_o,
  input  logic              aud_valid_i,
  input  logic              aud_hdr_i,
  input  logic [DATA_W-1:0] aud_data_i,
  output logic              aud_req_o,
  output logic              aud_acc_o,
  input  logic [NBUF-1:0]   rd_req_i,
  output logic [NBUF-1:0]   rd_gnt_o,
  output logic              mem_we_o,
  output logic              mem_re_o,
  output logic [ADDR_W-1:0] mem_addr_o,
  output logic [DATA_W-1:0] mem_wdata_o
);
  logic [NBUF-1:0]   full, empty, room, wr_en;
  logic [ADDR_W-1:0] wa [NBUF];
  logic [ADDR_W-1:0] ra [NBUF];
  buf_id_e           wsel, rsel;

  for (genvar g = 0; g < NBUF; g++) begin : g_ring
    chbuf_ring #(.ADDR_W(ADDR_W), .IDX(g)) u_ring (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .cfg_we_i   (cfg_we_i && (cfg_buf_i == BID_W'(g))),
      .cfg_field_i(cfg_field_e'(cfg_field_i)),
      .cfg_data_i (cfg_data_i),
      .wr_en_i    (wr_en[g]),
      .rd_en_i    (rd_gnt_o[g]),
      .wr_addr_o  (wa[g]),
      .rd_addr_o  (ra[g]),
      .full_o     (full[g]),
      .empty_o    (empty[g]),
      .room_o     (room[g])
    );
  end

  assign vid_req_o = room[BUF_VES] && (sys_mode_i ? room[BUF_AHDR] : room[BUF_VHDR]);
  assign aud_req_o = room[BUF_AES] && room[BUF_AHDR];

  chbuf_wr_route #(.DATA_W(DATA_W)) u_route (
    .sys_mode_i (sys_mode_i),
    .hold_i     (cfg_we_i),
    .vid_valid_i(vid_valid_i),
    .vid_hdr_i  (vid_hdr_i),
    .vid_data_i (vid_data_i),
    .vid_req_i  (vid_req_o),
    .aud_valid_i(aud_valid_i),
    .aud_hdr_i  (aud_hdr_i),
    .aud_data_i (aud_data_i),
    .aud_req_i  (aud_req_o),
    .full_i     (full),
    .vid_acc_o  (vid_acc_o),
    .aud_acc_o  (aud_acc_o),
    .wr_en_o    (wr_en),
    .sel_o      (wsel),
    .data_o     (mem_wdata_o)
  );

  chbuf_rd_arb u_rd_arb (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .block_i(mem_we_o || cfg_we_i),
    .req_i  (rd_req_i),
    .empty_i(empty),
    .gnt_o  (rd_gnt_o),
    .sel_o  (rsel)
  );

  assign mem_we_o   = |wr_en;
  assign mem_re_o   = |rd_gnt_o;
  assign mem_addr_o = mem_we_o ? wa[wsel] : ra[rsel];

  assert_one_op_R12 : assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(mem_we_o && mem_re_o));
  assert_vid_first_R11 : assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(vid_acc_o && aud_acc_o));
  assert_vid_req_gate_R10 : assert property (@(posedge clk_i) disable iff (!rst_ni)
    vid_acc_o |-> vid_req_o);
  assert_aud_req_gate_R10 : assert property (@(posedge clk_i) disable iff (!rst_ni)
    aud_acc_o |-> aud_req_o);
  assert_cfg_hold_R9 : assert property (@(posedge clk_i) disable iff (!rst_ni)
    cfg_we_i |-> !(mem_we_o || mem_re_o));
endmodule

// File: tb/chbuf_mgr_tb_top.sv
module chbuf_mgr_tb_top;
  localparam int CLK_P = 10;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        sys_mode_i = 1'b0;
  logic        cfg_we_i = 1'b0;
  logic [1:0]  cfg_buf_i = '0;
  logic [1:0]  cfg_field_i = '0;
  logic [15:0] cfg_data_i = '0;
  logic        vid_valid_i = 1'b0, vid_hdr_i = 1'b0;
  logic [7:0]  vid_data_i = '0;
  logic        aud_valid_i = 1'b0, aud_hdr_i = 1'b0;
  logic [7:0]  aud_data_i = '0;
  logic [3:0]  rd_req_i = '0;
  logic        vid_req_o, vid_acc_o, aud_req_o, aud_acc_o;
  logic [3:0]  rd_gnt_o;
  logic        mem_we_o, mem_re_o;
  logic [15:0] mem_addr_o;
  logic [7:0]  mem_wdata_o;

  int checks = 0;
  int fails  = 0;

  always #(CLK_P/2) clk_i = ~clk_i;

  chbuf_mgr dut_i (.*);

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk_i); #1;
  endtask

  task automatic cfg(int b, int f, int d);
    cfg_we_i = 1'b1; cfg_buf_i = 2'(b); cfg_field_i = 2'(f); cfg_data_i = 16'(d);
    tick();
    cfg_we_i = 1'b0;
  endtask

  task automatic region(int b, int pg);
    cfg(b, 0, pg);
    cfg(b, 1, pg);
  endtask

  // one video beat; check accept, write and address
  task automatic vbeat(string tag, bit hdr, logic [7:0] d, bit acc, logic [15:0] addr);
    vid_valid_i = 1'b1; vid_hdr_i = hdr; vid_data_i = d; #1;
    chk({tag, " vid_acc"}, vid_acc_o, acc);
    chk({tag, " mem_we"}, mem_we_o, acc);
    if (acc) begin
      chk({tag, " addr"}, mem_addr_o, addr);
      chk({tag, " wdata"}, mem_wdata_o, d);
    end
    tick();
    vid_valid_i = 1'b0;
  endtask

  task automatic abeat(string tag, bit hdr, logic [7:0] d, bit acc, logic [15:0] addr);
    aud_valid_i = 1'b1; aud_hdr_i = hdr; aud_data_i = d; #1;
    chk({tag, " aud_acc"}, aud_acc_o, acc);
    chk({tag, " mem_we"}, mem_we_o, acc);
    if (acc) chk({tag, " addr"}, mem_addr_o, addr);
    tick();
    aud_valid_i = 1'b0;
  endtask

  task automatic rd(string tag, logic [3:0] req, logic [3:0] gnt, logic [15:0] addr);
    rd_req_i = req; #1;
    chk({tag, " gnt"}, rd_gnt_o, gnt);
    chk({tag, " mem_re"}, mem_re_o, |gnt);
    if (|gnt) chk({tag, " addr"}, mem_addr_o, addr);
    tick();
    rd_req_i = '0;
  endtask

  task automatic t_reset();
    #1;
    chk("R1 vid_req", vid_req_o, 1);
    chk("R1 aud_req", aud_req_o, 1);
    chk("R1 mem_we", mem_we_o, 0);
    chk("R1 mem_re", mem_re_o, 0);
    chk("R1 gnt", rd_gnt_o, 0);
  endtask

  task automatic t_route();
    sys_mode_i = 1'b0;
    region(0, 8'h01); region(1, 8'h02); region(2, 8'h03); region(3, 8'h04);
    vbeat("R2 ves", 0, 8'hA1, 1, 16'h0100);
    vbeat("R2 vhdr", 1, 8'hA2, 1, 16'h0300);
    abeat("R2 aes", 0, 8'hB1, 1, 16'h0200);
    abeat("R2 ahdr", 1, 8'hB2, 1, 16'h0400);
    vbeat("R4 ves next", 0, 8'hA3, 1, 16'h0101);
  endtask

  task automatic t_sys();
    cfg(2, 0, 8'h03); cfg(3, 0, 8'h04);
    sys_mode_i = 1'b1;
    vbeat("R3 vhdr sys", 1, 8'hC1, 1, 16'h0400);
    vbeat("R3 vhdr sys2", 1, 8'hC2, 1, 16'h0401);
    rd("R3 R7 buf2 empty", 4'b0100, 4'b0000, 16'h0);
    rd("R3 buf3 read", 4'b1000, 4'b1000, 16'h0400);
    sys_mode_i = 1'b0;
  endtask

  task automatic t_prio();
    cfg(0, 0, 8'h01); cfg(1, 0, 8'h02);
    vid_valid_i = 1'b1; vid_hdr_i = 1'b0; aud_valid_i = 1'b1; aud_hdr_i = 1'b0; #1;
    chk("R11 vid wins acc", vid_acc_o, 1);
    chk("R11 aud loses", aud_acc_o, 0);
    chk("R11 vid addr", mem_addr_o, 16'h0100);
    tick();
    vid_valid_i = 1'b0;
    abeat("R11 aud alone", 0, 8'hD1, 1, 16'h0200);
    aud_valid_i = 1'b0;
    vid_valid_i = 1'b1; rd_req_i = 4'b0010; #1;
    chk("R11 write over read we", mem_we_o, 1);
    chk("R11 write over read re", mem_re_o, 0);
    chk("R11 write over read gnt", rd_gnt_o, 0);
    tick();
    vid_valid_i = 1'b0; rd_req_i = '0;
    rd("R11 rr b0", 4'b0011, 4'b0001, 16'h0100);
    rd("R11 rr b1", 4'b0011, 4'b0010, 16'h0200);
    rd("R11 rr b0 again", 4'b0011, 4'b0001, 16'h0101);
    rd("R7 both empty", 4'b0011, 4'b0000, 16'h0);
  endtask

  task automatic t_cfg();
    region(0, 8'h05); region(2, 8'h06);
    vbeat("R9 w0", 0, 8'h10, 1, 16'h0500);
    vbeat("R9 w1", 0, 8'h11, 1, 16'h0501);
    vbeat("R9 w2", 0, 8'h12, 1, 16'h0502);
    cfg(2, 0, 8'h06);
    vbeat("R9 other buf untouched", 0, 8'h13, 1, 16'h0503);
    vid_valid_i = 1'b1; cfg_we_i = 1'b1; cfg_buf_i = 2'd0; cfg_field_i = 2'd1; cfg_data_i = 16'h05; #1;
    chk("R9 no accept during cfg", vid_acc_o, 0);
    chk("R9 no write during cfg", mem_we_o, 0);
    tick();
    cfg_we_i = 1'b0; vid_valid_i = 1'b0;
    rd("R9 emptied", 4'b0001, 4'b0000, 16'h0);
    vbeat("R9 restart", 0, 8'h14, 1, 16'h0500);
  endtask

  task automatic t_full();
    region(1, 8'h10);
    for (int i = 0; i < 255; i++) abeat("R4 fill", 0, 8'(i), 1, 16'h1000 + 16'(i));
    abeat("R6 full refused", 0, 8'hEE, 0, 16'h0);
    rd("R8 read first", 4'b0010, 4'b0010, 16'h1000);
    abeat("R5 last byte", 0, 8'hF0, 1, 16'h10FF);
    abeat("R6 full again", 0, 8'hEF, 0, 16'h0);
    rd("R8 read second", 4'b0010, 4'b0010, 16'h1001);
    abeat("R5 write wraps", 0, 8'hF1, 1, 16'h1000);
    rd("R6 no overwrite", 4'b0010, 4'b0010, 16'h1002);
  endtask

  task automatic t_thr();
    region(0, 8'h20);
    cfg(0, 2, 250);
    for (int i = 0; i < 6; i++) vbeat("R10 fill", 0, 8'(i), 1, 16'h2000 + 16'(i));
    tick();
    chk("R10 req low below thr", vid_req_o, 0);
    chk("R10 aud req unaffected", aud_req_o, 1);
    vbeat("R10 beat refused", 0, 8'h55, 0, 16'h0);
    rd("R10 read1", 4'b0001, 4'b0001, 16'h2000);
    tick();
    chk("R10 req held at equal", vid_req_o, 0);
    rd("R10 read2", 4'b0001, 4'b0001, 16'h2001);
    tick();
    chk("R10 req back above thr", vid_req_o, 1);
    vbeat("R10 accepted again", 0, 8'h56, 1, 16'h2006);
  endtask

  initial begin
    #(CLK_P * 200000);
    fails++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    #(CLK_P * 3);
    @(negedge clk_i);
    rst_ni = 1'b1;
    tick();
    t_reset();
    t_route();
    t_sys();
    t_prio();
    t_cfg();
    t_full();
    t_thr();
    repeat (2) tick();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule